// File: doc/BRIEF.md
# Issue Scoreboard for an In-Order Multi-Unit Pipeline

This block decides, each cycle, whether the instruction sitting in the decode stage of an in-order pipeline may be sent to its functional unit. Four unit classes exist: integer, add, multiply and divide. Each class has a different latency. The block keeps two bit vectors:

- **Pending-write vector.** It has one bit per architectural register. A set bit means that an issued instruction has not yet written that register.
- **Busy vector.** It has one bit per unit class. Only units that cannot accept a new operation every cycle use this bit. By default that is the divider.

Decode presents four fields: a unit class, an optional destination and two source register numbers. The block compares them with the two vectors and answers with either an issue strobe or a stall, in the same cycle.

The block updates its state on the clock edge:

- An issue marks the destination register as pending. If the instruction goes to a non-pipelined unit, the issue also marks that unit busy.
- Each functional unit returns a write-enable and destination pair at writeback. That pair clears the register's pending bit.
- A per-unit done pulse frees a non-pipelined unit.

Register 0 never takes part in any hazard check.

Top module: `sb_issue_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `pend_vec` and `busy_vec` are all zeros.
- R2: An instruction whose unit class has its busy bit set is stalled. Unit class encoding: 0 integer, 1 add, 2 multiply, 3 divide.
- R3: An instruction is stalled when the pending bit of either source register is set (read-after-write).
- R4: An instruction that has a destination is stalled when the pending bit of that destination is set (write-after-write).
- R5: Dispatch is never blocked by a write-after-read relation. An instruction whose destination is a source of an older, still executing instruction issues as long as R2–R4 do not apply. This also holds when an instruction names the same register as both source and destination.
- R6: An issued instruction with a nonzero destination sets that register's bit in `pend_vec` from the next cycle on.
- R7: When `wb_en[u]` is high, bit `wb_dst[u*5 +: 5]` of `pend_vec` is clear on the next cycle. All four units may write back in the same cycle.
- R8: If a writeback clears a register in the same cycle that an issue sets it, the register is pending on the next cycle.
- R9: An instruction with `dec_has_dst` low skips the write-after-write check and sets no pending bit, whatever `dec_dst` holds.
- R10: Register 0 is ignored in every check. Bit 0 of `pend_vec` is never set, and a source or destination of 0 never causes a stall.
- R11: Issue to a non-pipelined unit (default: class 3 only) sets its busy bit from the next cycle on. `fu_done[u]` clears that bit on the next cycle. Busy bits of pipelined units are always 0, and their `fu_done` inputs have no effect.
- R12: `dec_issue` equals `dec_valid` and not blocked. `dec_stall` equals `dec_valid` and blocked. Both are combinational in the same cycle and are never high together. Both are low when `dec_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | A decoded instruction is present |
| dec_unit | input | 2 | Unit class of the instruction |
| dec_has_dst | input | 1 | Instruction writes a register |
| dec_dst | input | 5 | Destination register |
| dec_src1 | input | 5 | First source register |
| dec_src2 | input | 5 | Second source register |
| wb_en | input | 4 | Per-unit writeback enable |
| wb_dst | input | 20 | Per-unit writeback destination, 5 bits per unit |
| fu_done | input | 4 | Per-unit completion pulse for non-pipelined units |
| dec_issue | output | 1 | Instruction dispatches this cycle |
| dec_stall | output | 1 | Instruction is held this cycle |
| pend_vec | output | 32 | Pending-write vector |
| busy_vec | output | 4 | Unit busy vector |

## Verification
Two events can land on the same register in one cycle. A writeback can clear a register while the issuing instruction sets it as its destination. The bench provokes this by writing back a register that is not pending while issuing to it, and the reference model expects the set to win (R8). A second overlap occurs when several units write back at once, or when a writeback clears a register that the decoding instruction reads in the same cycle. The model keeps that instruction stalled, because the clear only takes effect on the edge. Random cycles confined to registers 0–7 raise all of these overlaps often, and every clock is compared against the behavioural model.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int SB_NUM_FU = 4;
  typedef enum logic [1:0] {
    FU_INT = 2'd0,
    FU_ADD = 2'd1,
    FU_MUL = 2'd2,
    FU_DIV = 2'd3
  } fu_class_e;
endpackage

// File: rtl/sb_pend_file.sv
module sb_pend_file #(
  parameter int NREG = 32,
  parameter int NFU  = 4,
  parameter int AW   = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [AW-1:0]     set_idx,
  input  logic [NFU-1:0]    wb_en,
  input  logic [NFU*AW-1:0] wb_dst,
  output logic [NREG-1:0]   pend_q
);
  logic [NREG-1:0] clr_mask;
  logic [NREG-1:0] set_mask;
  logic [NREG-1:0] pend_d;
  logic            pend_we;

  always_comb begin
    clr_mask = '0;
    for (int u = 0; u < NFU; u++) begin
      if (wb_en[u]) clr_mask[wb_dst[u*AW +: AW]] = 1'b1;
    end
    set_mask = '0;
    if (set_en) set_mask[set_idx] = 1'b1;
    pend_d    = (pend_q & ~clr_mask) | set_mask;
    pend_d[0] = 1'b0;
    pend_we   = set_en | (|wb_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_we) pend_q <= pend_d;
  end

  a_r6_set_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && set_idx != '0) |=> pend_q[$past(set_idx)]);

  a_r10_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q[0]);

  for (genvar u = 0; u < NFU; u++) begin : g_clr_chk
    a_r7_wb_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en[u] && !(set_en && set_idx == wb_dst[u*AW +: AW]))
        |=> !pend_q[$past(wb_dst[u*AW +: AW])]);
  end
endmodule

// File: rtl/sb_busy_ctrl.sv
module sb_busy_ctrl #(
  parameter int             NFU     = 4,
  parameter logic [NFU-1:0] NONPIPE = 4'b1000,
  parameter int             UW      = $clog2(NFU)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           set_en,
  input  logic [UW-1:0]  set_unit,
  input  logic [NFU-1:0] done,
  output logic [NFU-1:0] busy_q
);
  for (genvar u = 0; u < NFU; u++) begin : g_unit
    if (NONPIPE[u]) begin : g_np
      logic hit;
      logic busy_d;
      logic busy_we;
      always_comb begin
        hit     = set_en && (set_unit == UW'(u));
        busy_we = hit | done[u];
        busy_d  = hit;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       busy_q[u] <= 1'b0;
        else if (busy_we) busy_q[u] <= busy_d;
      end
      a_r11_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> busy_q[u]);
      a_r11_busy_free: assert property (@(posedge clk) disable iff (!rst_n)
        (done[u] && !hit) |=> !busy_q[u]);
    end else begin : g_pipe
      assign busy_q[u] = 1'b0;
    end
  end
endmodule

// File: rtl/sb_hazard_chk.sv
module sb_hazard_chk #(
  parameter int NREG = 32,
  parameter int NFU  = 4,
  parameter int AW   = $clog2(NREG),
  parameter int UW   = $clog2(NFU)
) (
  input  logic            dec_valid,
  input  logic [UW-1:0]   dec_unit,
  input  logic            dec_has_dst,
  input  logic [AW-1:0]   dec_dst,
  input  logic [AW-1:0]   dec_src1,
  input  logic [AW-1:0]   dec_src2,
  input  logic [NREG-1:0] pend,
  input  logic [NFU-1:0]  busy,
  output logic            issue,
  output logic            stall,
  output logic            mark_dst
);
  logic unit_blk, raw_blk, waw_blk, blocked, dst_live;

  always_comb begin
    dst_live = dec_has_dst && (dec_dst != '0);
    unit_blk = busy[dec_unit];
    raw_blk  = ((dec_src1 != '0) && pend[dec_src1]) ||
               ((dec_src2 != '0) && pend[dec_src2]);
    waw_blk  = dst_live && pend[dec_dst];
    blocked  = unit_blk | raw_blk | waw_blk;
    issue    = dec_valid && !blocked;
    stall    = dec_valid && blocked;
    mark_dst = issue && dst_live;
  end
endmodule

// File: rtl/sb_issue_ctrl.sv
module sb_issue_ctrl
  import sb_pkg::*;
#(
  parameter int                   NREG    = 32,
  parameter int                   NFU     = SB_NUM_FU,
  parameter logic [SB_NUM_FU-1:0] NONPIPE = 4'b1000,
  parameter int                   AW      = $clog2(NREG),
  parameter int                   UW      = $clog2(SB_NUM_FU)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid,
  input  logic [UW-1:0]     dec_unit,
  input  logic              dec_has_dst,
  input  logic [AW-1:0]     dec_dst,
  input  logic [AW-1:0]     dec_src1,
  input  logic [AW-1:0]     dec_src2,
  input  logic [NFU-1:0]    wb_en,
  input  logic [NFU*AW-1:0] wb_dst,
  input  logic [NFU-1:0]    fu_done,
  output logic              dec_issue,
  output logic              dec_stall,
  output logic [NREG-1:0]   pend_vec,
  output logic [NFU-1:0]    busy_vec
);
  logic mark_dst;

  sb_hazard_chk #(.NREG(NREG), .NFU(NFU), .AW(AW), .UW(UW)) u_chk (
    .dec_valid(dec_valid), .dec_unit(dec_unit), .dec_has_dst(dec_has_dst),
    .dec_dst(dec_dst), .dec_src1(dec_src1), .dec_src2(dec_src2),
    .pend(pend_vec), .busy(busy_vec),
    .issue(dec_issue), .stall(dec_stall), .mark_dst(mark_dst)
  );

  sb_pend_file #(.NREG(NREG), .NFU(NFU), .AW(AW)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_en(mark_dst), .set_idx(dec_dst),
    .wb_en(wb_en), .wb_dst(wb_dst), .pend_q(pend_vec)
  );

  sb_busy_ctrl #(.NFU(NFU), .NONPIPE(NONPIPE), .UW(UW)) u_busy (
    .clk(clk), .rst_n(rst_n), .set_en(dec_issue), .set_unit(dec_unit),
    .done(fu_done), .busy_q(busy_vec)
  );

  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_issue && dec_stall));
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !(dec_issue || dec_stall));
  a_r2_unit_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && busy_vec[dec_unit]) |-> dec_stall);
  a_r3_raw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_src1 != '0 && pend_vec[dec_src1]) |-> dec_stall);
  a_r4_waw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_has_dst && dec_dst != '0 && pend_vec[dec_dst]) |-> dec_stall);
  a_r9_nodst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_issue && !dec_has_dst && !(|wb_en)) |=> $stable(pend_vec));
endmodule

// File: tb/sb_issue_ctrl_bench.sv
module sb_issue_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        dec_valid, dec_has_dst;
  logic [1:0]  dec_unit;
  logic [4:0]  dec_dst, dec_src1, dec_src2;
  logic [3:0]  wb_en, fu_done;
  logic [19:0] wb_dst;
  logic        dec_issue, dec_stall;
  logic [31:0] pend_vec;
  logic [3:0]  busy_vec;

  logic [31:0] m_pend;
  logic [3:0]  m_busy;
  int total = 0;
  int bad = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  sb_issue_ctrl u_sb_issue_ctrl (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_unit(dec_unit),
    .dec_has_dst(dec_has_dst), .dec_dst(dec_dst), .dec_src1(dec_src1),
    .dec_src2(dec_src2), .wb_en(wb_en), .wb_dst(wb_dst), .fu_done(fu_done),
    .dec_issue(dec_issue), .dec_stall(dec_stall), .pend_vec(pend_vec),
    .busy_vec(busy_vec)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // One clock: drive, compare with the model mid-cycle, advance the model on the edge.
  task automatic step(input string tag, input logic v, input logic [1:0] u,
                      input logic hd, input logic [4:0] d, input logic [4:0] s1,
                      input logic [4:0] s2, input logic [3:0] we,
                      input logic [19:0] wd, input logic [3:0] dn);
    logic blk, iss;
    dec_valid = v; dec_unit = u; dec_has_dst = hd; dec_dst = d;
    dec_src1 = s1; dec_src2 = s2; wb_en = we; wb_dst = wd; fu_done = dn;
    #3;
    blk = m_busy[u] || (s1 != 0 && m_pend[s1]) || (s2 != 0 && m_pend[s2]) ||
          (hd && d != 0 && m_pend[d]);
    iss = v && !blk;
    check({tag, " R12 issue"}, 32'(dec_issue), 32'(iss));
    check({tag, " R12 stall"}, 32'(dec_stall), 32'(v && blk));
    check({tag, " pend"}, pend_vec, m_pend);
    check({tag, " busy"}, 32'(busy_vec), 32'(m_busy));
    @(posedge clk);
    for (int k = 0; k < 4; k++) begin
      if (we[k]) m_pend[wd[k*5 +: 5]] = 1'b0;
      if (dn[k]) m_busy[k] = 1'b0;
    end
    if (iss && hd && d != 0) m_pend[d] = 1'b1;
    if (iss && u == 2'd3) m_busy[3] = 1'b1;
    m_pend[0] = 1'b0;
    #1;
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    dec_valid = 0; dec_unit = 0; dec_has_dst = 0; dec_dst = 0;
    dec_src1 = 0; dec_src2 = 0; wb_en = 0; wb_dst = 0; fu_done = 0;
    m_pend = '0; m_busy = '0;
    #23;
    check("R1 reset pend", pend_vec, 32'd0);
    check("R1 reset busy", 32'(busy_vec), 32'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R6: multiply writes r5
    step("R6 set", 1, 2, 1, 5, 1, 2, 0, 0, 0);
    check("R6 pend r5", 32'(pend_vec[5]), 32'd1);
    // R3: read r5 while pending
    step("R3 raw src1", 1, 1, 1, 6, 5, 0, 0, 0, 0);
    step("R3 raw src2", 1, 0, 1, 6, 0, 5, 0, 0, 0);
    // R4: write r5 while pending
    step("R4 waw", 1, 0, 1, 5, 1, 2, 0, 0, 0);
    // R9: no destination field equals pending r5, issues and sets nothing
    step("R9 nodst", 1, 0, 0, 5, 1, 2, 0, 0, 0);
    step("R9 nodst2", 1, 1, 0, 9, 3, 4, 0, 0, 0);
    check("R9 no r9", 32'(pend_vec[9]), 32'd0);
    // R7: writeback from multiply unit clears r5; reader held in that same cycle
    step("R7 wb same cycle", 1, 1, 1, 6, 5, 0, 4'b0100, 20'(5) << 10, 0);
    check("R7 r5 cleared", 32'(pend_vec[5]), 32'd0);
    // R8: writeback of r9 (not pending) while issuing to r9
    step("R8 set wins", 1, 0, 1, 9, 0, 0, 4'b0001, 20'(9), 0);
    check("R8 r9 pending", 32'(pend_vec[9]), 32'd1);
    step("R7 multi wb", 0, 0, 0, 0, 0, 0, 4'b1111, {5'd9, 5'd6, 5'd0, 5'd9}, 0);
    // R10: register 0 everywhere
    step("R10 dst0", 1, 0, 1, 0, 0, 0, 0, 0, 0);
    check("R10 bit0", 32'(pend_vec[0]), 32'd0);
    step("R10 src0", 1, 1, 1, 3, 0, 0, 0, 0, 0);
    // R11 and R2: divider busy
    step("R11 div", 1, 3, 1, 7, 1, 1, 0, 0, 0);
    check("R11 busy set", 32'(busy_vec), 32'b1000);
    step("R2 div busy", 1, 3, 1, 8, 1, 1, 0, 0, 0);
    step("R11 pipe done ignored", 1, 2, 1, 10, 1, 1, 0, 0, 4'b0111);
    check("R11 pipe busy", 32'(busy_vec), 32'b1000);
    step("R11 done", 0, 0, 0, 0, 0, 0, 0, 0, 4'b1000);
    check("R11 busy clear", 32'(busy_vec), 32'b0000);
    // R5: older multiply reads r4, younger writes r4; and src==dst
    step("R5 older", 1, 2, 1, 11, 4, 4, 0, 0, 0);
    step("R5 war", 1, 0, 1, 4, 1, 2, 0, 0, 0);
    check("R5 r4 pending", 32'(pend_vec[4]), 32'd1);
    step("R5 self", 1, 1, 1, 12, 12, 12, 0, 0, 0);
    step("R7 flush", 0, 0, 0, 0, 0, 0, 4'b1111, {5'd3, 5'd4, 5'd11, 5'd12}, 4'b1000);

    for (int n = 0; n < 600; n++) begin
      step("R12 random", 1'($urandom_range(0, 3) != 0), 2'($urandom),
           1'($urandom_range(0, 4) != 0), 5'($urandom_range(0, 7)),
           5'($urandom_range(0, 7)), 5'($urandom_range(0, 7)),
           4'($urandom) & 4'($urandom),
           {5'($urandom_range(0, 7)), 5'($urandom_range(0, 7)),
            5'($urandom_range(0, 7)), 5'($urandom_range(0, 7))},
           4'($urandom_range(0, 5) == 0 ? 4'hF : 4'h0));
    end
    finish_run();
  end
endmodule